// File: doc/BRIEF.md
# Serial Most-Significant-First Magnitude Comparator

This block compares two unsigned binary numbers that arrive one bit pair per clock on two serial inputs, with the most significant bits first. After each clock edge it shows on three one-hot outputs whether the X operand is below, equal to, or above the Y operand, counting only the bit pairs taken in so far.

Because the bits come in from the top down, the first bit pair that differs settles the answer for the whole word. The machine holds that answer until a start pulse or a reset clears it. The word length has no fixed bound. The surrounding logic sets it by pulsing `start` together with the first bit pair of each word, and it reads the result on the clock after the last pair.

Top module: `serial_mag_cmp`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the machine in the equal state, so `x_eq_y`=1, `x_lt_y`=0 and `x_gt_y`=0 after that edge. The bit inputs sampled at that edge are ignored.
- R2: In the equal state, the pair x=0, y=1 moves the machine to the less-than state (`x_lt_y`=1). The pair x=1, y=0 moves it to the greater-than state (`x_gt_y`=1).
- R3: In the equal state, a pair of equal bits (00 or 11) leaves the machine in the equal state.
- R4: The less-than and greater-than states keep their value for any later bit pair, as long as neither `start` nor `rst` is high.
- R5: When `start` is high at an edge, the machine drops any earlier result and treats the pair sampled at that same edge as the first (most significant) pair of a new word.
- R6: Exactly one of `x_lt_y`, `x_eq_y` and `x_gt_y` is high in every cycle.
- R7: The outputs are decoded only from the registered state. After the edge that takes in bit pair k, they reflect pairs 1 through k.
- R8: The state is coded in two bits: equal = 00, less-than = 01, greater-than = 10. The unused code 11 goes back to the equal state at the next edge.
- R9: For an n-bit word started with `start`, the outputs after the n-th edge match the unsigned comparison of the two n-bit values, for any n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset to the equal state |
| start | input | 1 | Marks the first (most significant) bit pair of a word |
| x_bit | input | 1 | Serial bit of operand X |
| y_bit | input | 1 | Serial bit of operand Y |
| x_lt_y | output | 1 | High when X < Y over the bits seen so far |
| x_eq_y | output | 1 | High when X = Y over the bits seen so far |
| x_gt_y | output | 1 | High when X > Y over the bits seen so far |

## Verification
The outputs are a direct decode of the two state bits. A wrong state therefore shows up on the ports in the same cycle it is registered. The bench checks every prefix, one bit at a time, so an early mistake is not hidden by the final result. A decided state that fails to hold would show a flipped or cleared result after a later differing pair. A missed restart would carry the previous word's answer into the first bit of the next word. Exhaustive sweeps of short words and random 64-bit words with a single differing bit exercise both the early decisions and the late ones.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    typedef enum logic [1:0] {
        CMP_EQ  = 2'b00,
        CMP_LT  = 2'b01,
        CMP_GT  = 2'b10,
        CMP_BAD = 2'b11
    } cmp_state_e;

    typedef struct packed {
        cmp_state_e st;
    } cmp_regs_t;
endpackage

// File: rtl/cmp_step.sv
module cmp_step
    import cmp_pkg::*;
(
    input  cmp_state_e cur,
    input  logic       x_bit,
    input  logic       y_bit,
    output cmp_state_e nxt
);
    always_comb begin
        unique case (cur)
            CMP_EQ: begin
                if (x_bit && !y_bit)      nxt = CMP_GT;
                else if (!x_bit && y_bit) nxt = CMP_LT;
                else                      nxt = CMP_EQ;
            end
            CMP_LT:  nxt = CMP_LT;
            CMP_GT:  nxt = CMP_GT;
            default: nxt = CMP_EQ;
        endcase
    end
endmodule

// File: rtl/cmp_decode.sv
module cmp_decode
    import cmp_pkg::*;
(
    input  cmp_state_e st,
    output logic       lt,
    output logic       eq,
    output logic       gt
);
    always_comb begin
        lt = (st == CMP_LT);
        gt = (st == CMP_GT);
        eq = !(lt || gt);
    end
endmodule

// File: rtl/serial_mag_cmp.sv
module serial_mag_cmp
    import cmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic x_bit,
    input  logic y_bit,
    output logic x_lt_y,
    output logic x_eq_y,
    output logic x_gt_y
);
    cmp_regs_t  r_q, r_d;
    cmp_state_e base_st;
    cmp_state_e step_st;

    assign base_st = start ? CMP_EQ : r_q.st;

    cmp_step u_step (
        .cur   (base_st),
        .x_bit (x_bit),
        .y_bit (y_bit),
        .nxt   (step_st)
    );

    always_comb begin
        r_d    = r_q;
        r_d.st = step_st;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q.st <= CMP_EQ;
        else     r_q    <= r_d;
    end

    cmp_decode u_dec (
        .st (r_q.st),
        .lt (x_lt_y),
        .eq (x_eq_y),
        .gt (x_gt_y)
    );

    AST_RESET_EQ: assert property (@(posedge clk) rst |=> x_eq_y); // R1
    AST_EQ_TO_LT: assert property (@(posedge clk) disable iff (rst)
        (!start && r_q.st == CMP_EQ && !x_bit && y_bit) |=> x_lt_y); // R2
    AST_EQ_TO_GT: assert property (@(posedge clk) disable iff (rst)
        (!start && r_q.st == CMP_EQ && x_bit && !y_bit) |=> x_gt_y); // R2
    AST_EQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start && r_q.st == CMP_EQ && x_bit == y_bit) |=> x_eq_y); // R3
    AST_LT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!start && x_lt_y) |=> x_lt_y); // R4
    AST_GT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!start && x_gt_y) |=> x_gt_y); // R4
    AST_START_FIRST: assert property (@(posedge clk) disable iff (rst)
        (start && x_bit == y_bit) |=> x_eq_y); // R5
    AST_ONE_HOT: assert property (@(posedge clk)
        $countones({x_lt_y, x_eq_y, x_gt_y}) == 1); // R6
    AST_BAD_RECOVER: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == CMP_BAD) |=> (r_q.st == CMP_EQ)); // R8
endmodule

// File: tb/sim_serial_mag_cmp.sv
module sim_serial_mag_cmp;
    logic clk = 1'b0;
    logic rst, start, x_bit, y_bit;
    logic x_lt_y, x_eq_y, x_gt_y;
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    serial_mag_cmp u0 (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .x_bit  (x_bit),
        .y_bit  (y_bit),
        .x_lt_y (x_lt_y),
        .x_eq_y (x_eq_y),
        .x_gt_y (x_gt_y)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {lt,eq,gt} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_cmp(input logic [63:0] a, input logic [63:0] b);
        if (a < b)      return 3'b100;
        else if (a > b) return 3'b001;
        else            return 3'b010;
    endfunction

    // Feeds one word MSB first with start on the first pair; checks each prefix (R2, R3, R4, R7) and the final result (R9)
    task automatic run_word(input int w, input logic [63:0] xv, input logic [63:0] yv);
        for (int i = 0; i < w; i++) begin
            start = (i == 0);
            x_bit = xv[w-1-i];
            y_bit = yv[w-1-i];
            @(negedge clk);
            check("R7", {x_lt_y, x_eq_y, x_gt_y},
                  ref_cmp(xv >> (w-1-i), yv >> (w-1-i)));
            check("R6", {2'b00, ($countones({x_lt_y, x_eq_y, x_gt_y}) == 1)}, 3'b001);
        end
        check("R9", {x_lt_y, x_eq_y, x_gt_y}, ref_cmp(xv, yv));
        start = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; x_bit = 1'b1; y_bit = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", {x_lt_y, x_eq_y, x_gt_y}, 3'b010);
        rst = 1'b0;

        // R2 and R3 directed: 0/1 gives lt, 1/0 gives gt
        run_word(1, 64'd0, 64'd1);
        check("R2", {x_lt_y, x_eq_y, x_gt_y}, 3'b100);
        run_word(1, 64'd1, 64'd0);
        check("R2", {x_lt_y, x_eq_y, x_gt_y}, 3'b001);
        run_word(2, 64'd3, 64'd3);
        check("R3", {x_lt_y, x_eq_y, x_gt_y}, 3'b010);

        // R4: a decided result holds against opposite later bits without start
        run_word(2, 64'd2, 64'd1);
        for (int k = 0; k < 3; k++) begin
            x_bit = 1'b0; y_bit = 1'b1;
            @(negedge clk);
            check("R4", {x_lt_y, x_eq_y, x_gt_y}, 3'b001);
        end

        // R5: start with an equal first pair clears an earlier decision
        start = 1'b1; x_bit = 1'b1; y_bit = 1'b1;
        @(negedge clk);
        check("R5", {x_lt_y, x_eq_y, x_gt_y}, 3'b010);
        start = 1'b0;

        // Exhaustive sweep over widths 1 to 6
        for (int w = 1; w <= 6; w++)
            for (int a = 0; a < (1 << w); a++)
                for (int b = 0; b < (1 << w); b++)
                    run_word(w, 64'(a), 64'(b));

        // Long words: random, and equal except a single differing bit
        for (int k = 0; k < 100; k++) begin
            logic [63:0] xa, yb;
            xa = {$urandom, $urandom};
            yb = {$urandom, $urandom};
            run_word(64, xa, yb);
            yb = xa ^ (64'd1 << ($urandom % 64));
            run_word(64, xa, yb);
            run_word(40, xa & 64'hFF_FFFF_FFFF, xa & 64'hFF_FFFF_FFFF);
        end

        // R1 mid-word: reset wins over a differing pair
        run_word(3, 64'd5, 64'd4);
        rst = 1'b1; x_bit = 1'b0; y_bit = 1'b1;
        @(negedge clk);
        check("R1", {x_lt_y, x_eq_y, x_gt_y}, 3'b010);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule